// File: doc/BRIEF.md
# Serial Flash Status Command Responder

This block is the serial-side front end of a serial flash device that answers status instructions. While chip select is low, it collects an eight-bit opcode from the data-in pin on rising clock edges. Two opcodes start a status readout. Each readout repeats its status byte for as long as the host keeps clocking. A third opcode clears the write-enable latch. Every other opcode is ignored until chip select returns high.

The serial pins are oversampled by the core clock through a short synchronizer. Clock edges and chip select edges therefore become single-cycle events in the core domain. The block owns the write-enable latch, which is reported at bit 1 of the first status register:

- The latch is set by a pulse from the write-enable decoder elsewhere in the device.
- It is cleared by the disable instruction.
- It is also cleared by completion pulses from the program, erase and status-write engines.

Status reads are accepted whatever the busy input says, so a host can poll for the end of an internal operation.

Top module: `spi_status_responder`

## Requirements
- R1: After reset the write-enable latch reads 0 and `sdo_oe` is low.
- R2: Opcode 0x04 followed by chip select rising after exactly eight clock rises clears the latch. Any further rising edge before chip select rises cancels the instruction.
- R3: A pulse on any bit of `engine_done_i` clears the latch. A clear in the same cycle as `wel_set_i` wins.
- R4: A pulse on `wel_set_i` sets the latch.
- R5: Opcode 0x05 reads the first status byte MSB first: bits 7..2 are `sr1_ext_i`, bit 1 is the latch, bit 0 is `busy_i`.
- R6: Opcode 0x35 reads `sr2_ext_i`, MSB first.
- R7: While chip select stays low, the selected byte repeats without gaps. Its value is recaptured only at byte boundaries, so a change of `busy_i` mid-byte first appears in the following byte.
- R8: Status reads are served while `busy_i` is high.
- R9: `sdo_oe` stays low in these four cases:
  - while chip select is high;
  - during the opcode;
  - for the whole disable instruction;
  - after an unrecognised opcode.
- R10: Both clock polarities at chip select fall work: idle-low (mode 0) and idle-high (mode 3).
- R11: Chip select rising before the eighth opcode bit leaves the latch unchanged.
- R12: `sdo` changes only in response to a falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (low = high impedance) |
| busy_i | input | 1 | Internal operation in progress, reported at status bit 0 |
| wel_set_i | input | 1 | One-cycle pulse that sets the write-enable latch |
| engine_done_i | input | N_DONE | Completion pulses: status write, page program, sector/block/chip erase |
| sr1_ext_i | input | 6 | Upper six bits of the first status register |
| sr2_ext_i | input | 8 | Second status register value |

## Verification
Two pairs of events can land in the same core cycle, and both are handled by having a clear win.

The first pair is a latch set and a latch clear. The bench pulses `wel_set_i` together with one `engine_done_i` bit in a single cycle. It then judges the outcome by reading the first status byte: the latch bit must read 0.

The second pair is a byte-boundary recapture and a change of `busy_i`. The bench flips `busy_i` in the middle of the second repeated byte of a continuous read. It then expects the second byte to be intact and only the third byte to show the new busy value.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W = 8;
  localparam int OPC_W  = 8;

  localparam logic [OPC_W-1:0] OPC_WR_DIS = 8'h04;
  localparam logic [OPC_W-1:0] OPC_RD_ST1 = 8'h05;
  localparam logic [OPC_W-1:0] OPC_RD_ST2 = 8'h35;

  typedef enum logic [2:0] {
    ST_IDLE,  // chip select high
    ST_OPC,   // collecting opcode bits
    ST_READ,  // streaming a status byte
    ST_WRDI,  // disable armed, waiting for chip select rise
    ST_SKIP   // ignoring the rest of the frame
  } cmd_state_t;

  function automatic cmd_state_t classify(input logic [OPC_W-1:0] op);
    if (op == OPC_RD_ST1 || op == OPC_RD_ST2) return ST_READ;
    if (op == OPC_WR_DIS) return ST_WRDI;
    return ST_SKIP;
  endfunction

  function automatic logic is_read_op(input logic [OPC_W-1:0] op);
    return (op == OPC_RD_ST1) || (op == OPC_RD_ST2);
  endfunction

  function automatic logic [STAT_W-1:0] pack_sr1(input logic [STAT_W-3:0] ext,
                                                  input logic wel, input logic busy);
    return {ext, wel, busy};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic cs_s,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  // bit 2 = cs_n, bit 1 = sck, bit 0 = sdi
  localparam logic [2:0] PIN_RST = 3'b100;
  logic [2:0] pipe [STAGES];
  logic sck_q, cs_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= PIN_RST;
          else        pipe[g] <= {cs_n, sck, sdi};
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= PIN_RST;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= pipe[STAGES-1][1];
      cs_q  <= pipe[STAGES-1][2];
    end

  assign cs_s     = pipe[STAGES-1][2];
  assign sdi_s    = pipe[STAGES-1][0];
  assign sck_rise =  pipe[STAGES-1][1] & ~sck_q;
  assign sck_fall = ~pipe[STAGES-1][1] &  sck_q;
  assign cs_rise  =  pipe[STAGES-1][2] & ~cs_q;
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sdi_s,
  input  logic sck_rise,
  input  logic cs_rise,
  output logic op_done,
  output logic read_load,
  output logic sel_sr2,
  output logic in_read,
  output logic wrdi_evt
);
  localparam int CNT_W = $clog2(OPC_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OPC_W - 1);

  cmd_state_t state_q;
  logic [OPC_W-1:0] op_q, op_next;
  logic [CNT_W-1:0] cnt_q;
  logic sel_q;

  assign op_next   = {op_q[OPC_W-2:0], sdi_s};
  assign op_done   = (state_q == ST_OPC) && !cs_s && sck_rise && (cnt_q == LAST_BIT);
  assign read_load = op_done && is_read_op(op_next);
  assign sel_sr2   = (state_q == ST_READ) ? sel_q : (op_next == OPC_RD_ST2);
  assign in_read   = (state_q == ST_READ);
  assign wrdi_evt  = cs_rise && (state_q == ST_WRDI);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else if (cs_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_OPC;
          cnt_q   <= '0;
        end
        ST_OPC: if (sck_rise) begin
          op_q  <= op_next;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            state_q <= classify(op_next);
            sel_q   <= (op_next == OPC_RD_ST2);
          end
        end
        ST_WRDI: if (sck_rise) state_q <= ST_SKIP;
        default: ;
      endcase
    end
endmodule

// File: rtl/spi_stat_shifter.sv
module spi_stat_shifter
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              active,
  input  logic              sck_fall,
  input  logic [STAT_W-1:0] value,
  output logic              sdo
);
  localparam int IDX_W = $clog2(STAT_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STAT_W - 1);

  logic [STAT_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      byte_q <= '0;
      idx_q  <= '0;
      sdo    <= 1'b0;
    end else if (load) begin
      byte_q <= value;
      idx_q  <= '0;
    end else if (active && sck_fall) begin
      sdo <= byte_q[STAT_W-1];
      if (idx_q == LAST_IDX) begin
        byte_q <= value;          // recapture at the byte boundary
        idx_q  <= '0;
      end else begin
        byte_q <= {byte_q[STAT_W-2:0], 1'b0};
        idx_q  <= idx_q + 1'b1;
      end
    end
endmodule

// File: rtl/spi_wel_latch.sv
module spi_wel_latch #(
  parameter int N_DONE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              wrdi_i,
  input  logic [N_DONE-1:0] done_i,
  output logic              clr_o,
  output logic              wel_o
);
  assign clr_o = wrdi_i | (|done_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_o) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
endmodule

// File: rtl/spi_status_responder.sv
module spi_status_responder
  import spi_stat_pkg::*;
#(
  parameter int N_DONE      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              busy_i,
  input  logic              wel_set_i,
  input  logic [N_DONE-1:0] engine_done_i,
  input  logic [STAT_W-3:0] sr1_ext_i,
  input  logic [STAT_W-1:0] sr2_ext_i
);
  logic cs_s, sdi_s, sck_rise_e, sck_fall_e, cs_rise_e;
  logic op_done_e, read_load, sel_sr2, in_read, wrdi_e;
  logic wel_q, wel_clr;
  logic [STAT_W-1:0] stat_val;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .cs_s(cs_s), .sdi_s(sdi_s), .sck_rise(sck_rise_e),
    .sck_fall(sck_fall_e), .cs_rise(cs_rise_e)
  );

  spi_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdi_s(sdi_s),
    .sck_rise(sck_rise_e), .cs_rise(cs_rise_e), .op_done(op_done_e),
    .read_load(read_load), .sel_sr2(sel_sr2), .in_read(in_read),
    .wrdi_evt(wrdi_e)
  );

  spi_wel_latch #(.N_DONE(N_DONE)) u_wel (
    .clk(clk), .rst_n(rst_n), .set_i(wel_set_i), .wrdi_i(wrdi_e),
    .done_i(engine_done_i), .clr_o(wel_clr), .wel_o(wel_q)
  );

  assign stat_val = sel_sr2 ? sr2_ext_i : pack_sr1(sr1_ext_i, wel_q, busy_i);

  spi_stat_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(read_load), .active(in_read),
    .sck_fall(sck_fall_e), .value(stat_val), .sdo(sdo)
  );

  assign sdo_oe = in_read;
endmodule

// File: rtl/spi_status_responder_chk.sv
module spi_status_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic sdo,
  input logic sdo_oe,
  input logic wel_q,
  input logic wel_clr,
  input logic wel_set_i,
  input logic sck_fall_e,
  input logic cs_rise_e,
  input logic op_done_e
);
  assert_wel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_q);

  assert_wel_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set_i && !wel_clr) |=> wel_q);

  // R11: with neither set nor clear the latch keeps its value
  assert_wel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel_set_i && !wel_clr) |=> $stable(wel_q));

  assert_sdo_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall_e |=> $stable(sdo));

  assert_oe_off_after_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_e |=> !sdo_oe);

  assert_oe_after_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(op_done_e));
endmodule

bind spi_status_responder spi_status_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .wel_q(wel_q),
  .wel_clr(wel_clr), .wel_set_i(wel_set_i), .sck_fall_e(sck_fall_e),
  .cs_rise_e(cs_rise_e), .op_done_e(op_done_e)
);

// File: tb/sim_spi_status_responder.sv
`timescale 1ns/1ps
module sim_spi_status_responder;
  localparam int N_DONE = 5;
  localparam int HALF   = 10;   // core cycles per serial half period
  localparam logic [5:0] EXT1 = 6'h2A;
  localparam logic [7:0] EXT2 = 8'h5C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic busy = 1'b0, wel_set = 1'b0;
  logic [N_DONE-1:0] done = '0;

  int n_chk = 0, n_fail = 0;
  bit wel_m = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  spi_status_responder #(.N_DONE(N_DONE), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy_i(busy), .wel_set_i(wel_set),
    .engine_done_i(done), .sr1_ext_i(EXT1), .sr2_ext_i(EXT2)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sr1_exp();
    return {EXT1, wel_m, busy};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: assembles bytes at each rising serial clock while enabled
  logic [7:0] mon_sh;
  int mon_cnt = 0;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) mon_cnt = 0;
    else if (sdo_oe) begin
      mon_sh = {mon_sh[6:0], sdo};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected byte", mon_sh, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(mon_sh == e, t, mon_sh, e);
        end
      end
    end
  end

  // One serial bit; data out changes at the falling edge, sampled at the rise
  task automatic bit_cycle(input logic b);
    sck = 1'b0; sdi = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic frame_start(input bit mode3);
    sck = mode3; wait_clk(HALF);
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic frame_end(input bit mode3);
    if (!mode3) begin sck = 1'b0; wait_clk(HALF); end
    cs_n = 1'b1; wait_clk(2 * HALF);
  endtask

  task automatic send_op(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) bit_cycle(op[i]);
  endtask

  // Read n bytes; expectations pushed up front; busy may rise after data rise flip_at
  task automatic read_bytes(input logic [7:0] op, input int n, input bit mode3,
                            input int flip_at, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      bit newbusy = (flip_at >= 0) && (k > 0) && (8 * k - 1 > flip_at);
      if (op == 8'h35) e = EXT2;
      else e = {EXT1, wel_m, (newbusy ? 1'b1 : busy)};
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    frame_start(mode3);
    send_op(op);
    for (int d = 0; d < 8 * n; d++) begin
      bit_cycle(1'b0);
      if (d == flip_at) busy = 1'b1;
    end
    frame_end(mode3);
  endtask

  task automatic pulse_set();
    wel_set = 1'b1; wait_clk(1); wel_set = 1'b0; wait_clk(2);
    wel_m = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int quiet_bad;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1: reset state
    check(sdo_oe == 1'b0, "R1 oe after reset", sdo_oe, 0);
    read_bytes(8'h05, 1, 1'b0, -1, "R1 R5 SR1 after reset");

    // R4 + R7: set latch, continuous read repeats
    pulse_set();
    read_bytes(8'h05, 2, 1'b0, -1, "R4 R7 SR1 repeated");

    // R2 + R9 + R10: disable in mode 3, oe stays low
    frame_start(1'b1);
    quiet_bad = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(i == 2);
      if (sdo_oe) quiet_bad++;
    end
    wait_clk(HALF);
    check(sdo_oe == 1'b0 && quiet_bad == 0, "R9 oe during disable", quiet_bad, 0);
    frame_end(1'b1);
    wel_m = 1'b0;
    read_bytes(8'h05, 1, 1'b1, -1, "R2 R10 SR1 after disable");

    // R2: an extra bit after the opcode cancels the disable
    pulse_set();
    frame_start(1'b0);
    send_op(8'h04);
    bit_cycle(1'b0);
    frame_end(1'b0);
    read_bytes(8'h05, 1, 1'b0, -1, "R2 disable cancelled by extra bit");

    // R11: chip select rises after four opcode bits
    frame_start(1'b0);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0);
    frame_end(1'b0);
    read_bytes(8'h05, 1, 1'b0, -1, "R11 aborted opcode");

    // R3: each completion pulse clears the latch
    for (int i = 0; i < N_DONE; i++) begin
      pulse_set();
      done[i] = 1'b1; wait_clk(1); done = '0; wait_clk(2);
      wel_m = 1'b0;
      read_bytes(8'h05, 1, 1'b0, -1, "R3 completion clears latch");
    end

    // R3: set and clear in the same cycle, clear wins
    wel_set = 1'b1; done[2] = 1'b1; wait_clk(1);
    wel_set = 1'b0; done = '0; wait_clk(2);
    wel_m = 1'b0;
    read_bytes(8'h05, 1, 1'b0, -1, "R3 clear beats set");

    // R6 + R8 + R10: reads while busy, mode 3
    busy = 1'b1;
    read_bytes(8'h35, 3, 1'b1, -1, "R6 R8 SR2 while busy");
    read_bytes(8'h05, 2, 1'b0, -1, "R8 SR1 shows busy");

    // R7: busy rises mid second byte, third byte shows it
    busy = 1'b0;
    pulse_set();
    read_bytes(8'h05, 3, 1'b0, 11, "R7 busy change at boundary");

    // R9: unknown opcode keeps output disabled
    frame_start(1'b0);
    send_op(8'h9F);
    quiet_bad = 0;
    for (int d = 0; d < 16; d++) begin
      bit_cycle(1'b1);
      if (sdo_oe) quiet_bad++;
    end
    frame_end(1'b0);
    check(quiet_bad == 0, "R9 unknown opcode oe", quiet_bad, 0);
    check(sdo_oe == 1'b0, "R9 oe with chip select high", sdo_oe, 0);
    check(exp_q.size() == 0, "R7 all expected bytes seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule